// File: doc/BRIEF.md
# Tick-Paced LED Stepping Processor

This block is a very small sequential processor that runs a fixed program from an on-chip ROM and shows the contents of its only working register on three LED lines. A free-running counter on the system clock sets the pace. Each time the counter's top bit rises, the processor does one step: it fetches the word at the program counter, decodes it, executes it, and moves the program counter to the next word. The pace is slow enough that a person can watch the LEDs change.

The instruction set has two operations, picked by the upper nibble of an 8-bit word. One adds one to the 3-bit accumulator, which wraps around. The other copies the accumulator to the LED latch. Every other opcode does nothing except advance the program counter. The whole block runs on one clock. The slow pace is a one-cycle enable and is never used as a clock. The block carries no data stream, so it has no valid/ready handshake. Its pins are a clock, a synchronous reset and the LED output.

The ROM contents are fixed when the design is built. Take a program of depth D, where each word holds its own address modulo 16 in its low nibble. The even addresses below D-2 increment the accumulator. The odd addresses below D-2 output the accumulator. Address D-2 holds opcode 0x0 and address D-1 holds opcode 0xC, so both of those are no-ops.

Top module: `tick_led_cpu`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge clears the program counter, the accumulator, the LED output and the tick counter to zero.
- R2: The tick counter is CNT_W bits wide, counts up by one each clock cycle and starts from zero after reset. A step happens only at the clock edge that follows a cycle in which counter bit CNT_W-1 has just changed from 0 to 1. The first step comes at edge 2^(CNT_W-1)+1 after reset is released, and each later step comes 2^CNT_W edges after the one before.
- R3: Opcode 4'b0001 in bits [7:4] adds one to the 3-bit accumulator, modulo 8, so 7 wraps to 0.
- R4: Opcode 4'b0010 in bits [7:4] loads the LED output with the current value of the accumulator.
- R5: Any other value in bits [7:4] leaves the accumulator and the LED output unchanged.
- R6: The program counter advances by one on every step, whatever the opcode. It wraps from PROG_DEPTH-1 to 0, so the program repeats for ever.
- R7: Bits [3:0] of an instruction word have no effect on execution.
- R8: The LED output changes only on a step that executes opcode 4'b0010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| led | output | LED_W (3) | LED latch, one bit per colour channel |

## Verification
The bench builds the block with CNT_W = 4, so a step happens every 16 clock cycles and one full pass of the 16-word program takes 256 cycles. This brings several program loops within a few thousand cycles. That covers many accumulator wraps, both no-op words and the program counter's wrap from 15 to 0. Resets come at random points and in one directed burst, so the bench sees a reset land in the middle of the tick period and in the middle of the program.

// File: rtl/led_cpu_pkg.sv
package led_cpu_pkg;
  localparam int WORD_W = 8;
  localparam int OPC_W  = 4;

  localparam logic [OPC_W-1:0] OPC_INC = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_OUT = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_NOP = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_ODD = 4'b1100;

  // Program word for address idx of a program with depth words.
  function automatic logic [WORD_W-1:0] prog_word(input int idx, input int depth);
    logic [OPC_W-1:0] opc;
    logic [31:0]      iv;
    iv = idx;
    if (idx < depth - 2) opc = iv[0] ? OPC_OUT : OPC_INC;
    else if (idx == depth - 2) opc = OPC_NOP;
    else opc = OPC_ODD;
    return {opc, iv[3:0]};
  endfunction
endpackage

// File: rtl/lc_tick_gen.sv
module lc_tick_gen #(
  parameter int CNT_W = 25
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TOP = CNT_W - 1;

  logic [CNT_W-1:0] cnt;
  logic             top_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      top_q <= 1'b0;
    end else begin
      cnt   <= cnt + 1'b1;
      top_q <= cnt[TOP];
    end
  end

  assign tick = cnt[TOP] & ~top_q;

  // R2: the enable never lasts two cycles
  a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/lc_prog_rom.sv
module lc_prog_rom
  import led_cpu_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0]     addr,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign mem[g] = prog_word(g, DEPTH);
  end

  assign word = mem[addr];
endmodule

// File: rtl/lc_exec_core.sv
module lc_exec_core
  import led_cpu_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LED_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [WORD_W-1:0] word,
  output logic [AW-1:0]     pc,
  output logic [LED_W-1:0]  led
);
  logic [LED_W-1:0] acc;
  logic [OPC_W-1:0] opc;

  assign opc = word[WORD_W-1 -: OPC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      acc <= '0;
      led <= '0;
    end else if (tick) begin
      pc <= pc + 1'b1;
      case (opc)
        OPC_INC: acc <= acc + 1'b1;
        OPC_OUT: led <= acc;
        default: ;
      endcase
    end
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pc == '0 && acc == '0 && led == '0));
  // R3
  a_r3_inc_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && opc == OPC_INC) |=> acc == LED_W'($past(acc) + 1));
  // R4
  a_r4_out_copy: assert property (@(posedge clk) disable iff (rst)
    (tick && opc == OPC_OUT) |=> led == $past(acc));
  // R5
  a_r5_other_hold: assert property (@(posedge clk) disable iff (rst)
    (tick && opc != OPC_INC && opc != OPC_OUT) |=> $stable(acc) && $stable(led));
  // R6
  a_r6_pc_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> pc == AW'($past(pc) + 1));
  // R8
  a_r8_led_hold: assert property (@(posedge clk) disable iff (rst)
    !(tick && opc == OPC_OUT) |=> $stable(led));
endmodule

// File: rtl/tick_led_cpu.sv
module tick_led_cpu
  import led_cpu_pkg::*;
#(
  parameter int CNT_W      = 25,
  parameter int PROG_DEPTH = 16,
  parameter int LED_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [LED_W-1:0] led
);
  localparam int AW = $clog2(PROG_DEPTH);

  logic              tick;
  logic [AW-1:0]     pc;
  logic [WORD_W-1:0] word;

  lc_tick_gen #(.CNT_W(CNT_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  lc_prog_rom #(.DEPTH(PROG_DEPTH), .AW(AW)) u_rom (
    .addr (pc),
    .word (word)
  );

  lc_exec_core #(.AW(AW), .LED_W(LED_W)) u_core (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .word (word),
    .pc   (pc),
    .led  (led)
  );
endmodule

// File: tb/sim_tick_led_cpu.sv
module sim_tick_led_cpu;
  localparam int CW    = 4;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] led;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_led_cpu #(.CNT_W(CW), .PROG_DEPTH(DEPTH), .LED_W(3)) u0 (
    .clk (clk),
    .rst (rst),
    .led (led)
  );

  logic [CW-1:0] m_cnt;
  logic          m_prev;
  logic [3:0]    m_pc;
  logic [2:0]    m_a;
  logic [2:0]    m_led;
  int            m_loops;
  string         tag;

  // Opcode nibble the requirements place at each address
  function automatic logic [3:0] exp_opc(input logic [3:0] a);
    if (a < DEPTH - 2) return a[0] ? 4'b0010 : 4'b0001;
    else if (a == DEPTH - 2) return 4'b0000;
    else return 4'b1100;
  endfunction

  task automatic model_step(input bit r);
    logic [3:0] op;
    if (r) begin
      m_cnt = '0; m_prev = 0; m_pc = '0; m_a = '0; m_led = '0;
      m_loops = 0; tag = "R1";
    end else begin
      if (m_cnt[CW-1] && !m_prev) begin
        op = exp_opc(m_pc);
        case (op)
          4'b0001: begin m_a = m_a + 3'd1; tag = "R3 R8"; end
          4'b0010: begin m_led = m_a; tag = (m_loops > 0) ? "R6" : "R4"; end
          default: tag = "R5 R7";
        endcase
        m_pc = m_pc + 4'd1;
        if (m_pc == 4'd0) m_loops++;
      end else begin
        tag = "R2";
      end
      m_prev = m_cnt[CW-1];
      m_cnt = m_cnt + 1'b1;
    end
  endtask

  task automatic check_led();
    checks++;
    if (led !== m_led) begin
      errs++;
      $display("FAIL %s: led actual=%0d expected=%0d at %0t", tag, led, m_led, $time);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1;
    model_step(1'b1);
    @(negedge clk);
    @(negedge clk);
    check_led();
    for (int i = 0; i < 3200; i++) begin
      bit r;
      r = 0;
      if (i >= 1500 && i < 1503) r = 1;
      else if (i > 900 && ($urandom % 600) == 0) r = 1;
      rst = r;
      model_step(r);
      @(negedge clk);
      check_led();
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule